// File: doc/BRIEF.md
# Interval Pulse Generator

This block makes periodic output pulses from a frequency-compensated time base. It is typically used to give one pulse per second for clock synchronisation. A shared strobe, `tickAdv`, marks each time the time counter moves forward by one nominal tick of `TICK_NS` nanoseconds. A second shared strobe, `outClkEn`, marks each period of the prescaled output clock. `NUM_GEN` independent generators use both strobes. Each generator has its own interval register, its own enable, a pulse output, a sticky event flag and an overrun flag.

Each generator holds a down-counter in nanoseconds. The counter loses one tick on every advance. The advance that finds less than one tick left fires a pulse, and the counter then reloads from the interval register. The pulse period is therefore the programmed interval plus one tick. Software programs the desired period minus one tick: with a 5 ns tick, one second is programmed as 999,999,995 ns. The output pulse is registered, and it stays high until one output-clock strobe has been seen while it is high. Every firing sets the event flag. A firing that finds the flag still set raises the overrun flag. Both flags are cleared by write-one strobes.

Top module: `interval_pulse_gen`

## Requirements
- R1: After reset, `pulseOut`, `evtFlag` and `ovrFlag` are all zero for every generator, and every interval register and down-counter holds zero.
- R2: When `intervalWr[g]` is high at a clock edge, generator g stores `intervalData` as its interval and loads it into its down-counter. Generator g then fires on advance number floor(V/`TICK_NS`)+1 after the write, where V is the stored interval.
- R3: An enabled generator with interval V fires once every floor(V/`TICK_NS`)+1 advances, indefinitely. A fire is an advance at which the counter holds less than `TICK_NS`. At a fire the counter reloads V; at any other advance it drops by `TICK_NS`.
- R4: The down-counter changes only on cycles with `tickAdv` high. Cycles without an advance neither count nor fire, however many of them there are.
- R5: While `genEnable[g]` is low, generator g never fires, and its counter is held at the interval value. After the enable returns high, the first fire comes on advance floor(V/`TICK_NS`)+1.
- R6: A write to the interval register in the same cycle as an advance that would otherwise fire suppresses that fire. No pulse and no event result from it.
- R7: A fire at edge k drives `pulseOut[g]` high from edge k onward. The pulse stays high until the edge at which `outClkEn` is high while the pulse is already high, and it goes low after that edge. A new fire at that same edge keeps it high.
- R8: Each fire sets `evtFlag[g]`. The flag stays set until an edge with `evtClr[g]` high. A fire in the same cycle as the clear wins, and the flag stays set.
- R9: A fire while `evtFlag[g]` is set and is not being cleared in that cycle sets `ovrFlag[g]`. The overrun flag stays set until an edge with `ovrClr[g]` high, and a new overrun in that cycle wins over the clear.
- R10: Generators are independent. Each has its own interval, counter, enable, pulse and flags. A write, enable change or clear aimed at one generator leaves the others unchanged.
- R11: An interval of zero, or any value below `TICK_NS`, makes the generator fire on every advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickAdv | input | 1 | Time counter advanced by one nominal tick this cycle |
| outClkEn | input | 1 | One-cycle strobe per prescaled output-clock period |
| intervalWr | input | NUM_GEN | Per-generator interval write strobe |
| intervalData | input | CNT_W | Interval value in ns, shared by all generators |
| genEnable | input | NUM_GEN | Per-generator enable |
| evtClr | input | NUM_GEN | Write-one-to-clear strobe for the event flags |
| ovrClr | input | NUM_GEN | Write-one-to-clear strobe for the overrun flags |
| pulseOut | output | NUM_GEN | Registered periodic output pulses |
| evtFlag | output | NUM_GEN | Sticky event flags |
| ovrFlag | output | NUM_GEN | Sticky overrun flags |

## Verification
The hardest case to reach from the ports is an interval write that lands on exactly the advance that would fire. To reach it, the stimulus counts advances from a known write, so the counter is known to be below one tick, and then raises the write strobe together with that advance. Disabling in the middle of a count and the set-versus-clear collisions on both flags are set up the same way. The stimulus counts advances from a known reload, then lines the second event up with the firing advance. A reference model in the bench predicts the cycle of every pulse rise, across dense and sparse advance patterns.

// File: rtl/ipg_pkg.sv
package ipg_pkg;

  // Strobes from control to datapath, one set per generator per cycle
  typedef struct packed {
    logic load;     // take a new interval from the bus
    logic restart;  // reload counter from stored interval (disabled)
    logic step;     // subtract one tick
    logic fire;     // counter expired on this advance: reload and pulse
  } ipgStrobe_t;

endpackage

// File: rtl/ipg_dpath.sv
module ipg_dpath
  import ipg_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int TICK_NS = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ipgStrobe_t       strobes,
  input  logic [CNT_W-1:0] wrData,
  output logic             cntLow
);

  localparam logic [CNT_W-1:0] TICK_STEP = CNT_W'(TICK_NS);

  logic [CNT_W-1:0] intervalQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntD;

  always_comb begin
    cntD = cntQ;
    if (strobes.load) begin
      cntD = wrData;
    end else if (strobes.restart || strobes.fire) begin
      cntD = intervalQ;
    end else if (strobes.step) begin
      cntD = cntQ - TICK_STEP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalQ <= '0;
      cntQ      <= '0;
    end else begin
      if (strobes.load) begin
        intervalQ <= wrData;
      end
      cntQ <= cntD;
    end
  end

  // Remaining time is below one tick: the next advance fires
  assign cntLow = (cntQ < TICK_STEP);

  AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (cntQ == $past(wrData)) && (intervalQ == $past(wrData))); // R2

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (cntQ == $past(cntQ) - TICK_STEP)); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.load || strobes.restart || strobes.fire || strobes.step) |=> $stable(cntQ)); // R4

  AST_FIRE_RELOADS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fire |=> (cntQ == intervalQ)); // R3

endmodule

// File: rtl/ipg_ctrl.sv
module ipg_ctrl
  import ipg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickAdv,
  input  logic       outClkEn,
  input  logic       wrEn,
  input  logic       enable,
  input  logic       evtClr,
  input  logic       ovrClr,
  input  logic       cntLow,
  output ipgStrobe_t strobes,
  output logic       pulseQ,
  output logic       evtQ,
  output logic       ovrQ
);

  logic running;
  logic pulseD;
  logic evtD;
  logic ovrD;

  assign running = enable && !wrEn;

  always_comb begin
    strobes         = '0;
    strobes.load    = wrEn;
    strobes.restart = !wrEn && !enable;
    strobes.fire    = running && tickAdv && cntLow;
    strobes.step    = running && tickAdv && !cntLow;
  end

  // Pulse: set on fire, released by the first output-clock strobe seen while high
  always_comb begin
    pulseD = pulseQ;
    if (strobes.fire) begin
      pulseD = 1'b1;
    end else if (pulseQ && outClkEn) begin
      pulseD = 1'b0;
    end
  end

  // Sticky flags: setting wins over a same-cycle clear
  always_comb begin
    evtD = evtQ;
    if (strobes.fire) begin
      evtD = 1'b1;
    end else if (evtClr) begin
      evtD = 1'b0;
    end
  end

  always_comb begin
    ovrD = ovrQ;
    if (strobes.fire && evtQ && !evtClr) begin
      ovrD = 1'b1;
    end else if (ovrClr) begin
      ovrD = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseQ <= 1'b0;
      evtQ   <= 1'b0;
      ovrQ   <= 1'b0;
    end else begin
      pulseQ <= pulseD;
      evtQ   <= evtD;
      ovrQ   <= ovrD;
    end
  end

  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ && !outClkEn |=> pulseQ); // R7

  AST_PULSE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ && outClkEn && !strobes.fire |=> !pulseQ); // R7

  AST_NO_PULSE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !$rose(pulseQ)); // R5

  AST_NO_PULSE_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !pulseQ |=> !pulseQ); // R6

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    evtQ && !evtClr |=> evtQ); // R8

  AST_OVR_AFTER_EVT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrQ) |-> $past(evtQ)); // R9

  AST_PULSE_FROM_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseQ) |-> $past(tickAdv && enable)); // R4

endmodule

// File: rtl/interval_pulse_gen.sv
module interval_pulse_gen
  import ipg_pkg::*;
#(
  parameter int NUM_GEN = 2,
  parameter int CNT_W   = 32,
  parameter int TICK_NS = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickAdv,
  input  logic               outClkEn,
  input  logic [NUM_GEN-1:0] intervalWr,
  input  logic [CNT_W-1:0]   intervalData,
  input  logic [NUM_GEN-1:0] genEnable,
  input  logic [NUM_GEN-1:0] evtClr,
  input  logic [NUM_GEN-1:0] ovrClr,
  output logic [NUM_GEN-1:0] pulseOut,
  output logic [NUM_GEN-1:0] evtFlag,
  output logic [NUM_GEN-1:0] ovrFlag
);

  for (genvar g = 0; g < NUM_GEN; g++) begin : gGen
    ipgStrobe_t strobes;
    logic       cntLow;

    ipg_ctrl uCtrl (
      .clk      (clk),
      .rstN     (rstN),
      .tickAdv  (tickAdv),
      .outClkEn (outClkEn),
      .wrEn     (intervalWr[g]),
      .enable   (genEnable[g]),
      .evtClr   (evtClr[g]),
      .ovrClr   (ovrClr[g]),
      .cntLow   (cntLow),
      .strobes  (strobes),
      .pulseQ   (pulseOut[g]),
      .evtQ     (evtFlag[g]),
      .ovrQ     (ovrFlag[g])
    );

    ipg_dpath #(
      .CNT_W   (CNT_W),
      .TICK_NS (TICK_NS)
    ) uDpath (
      .clk     (clk),
      .rstN    (rstN),
      .strobes (strobes),
      .wrData  (intervalData),
      .cntLow  (cntLow)
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pulseOut == '0) && (evtFlag == '0) && (ovrFlag == '0)); // R1

endmodule

// File: tb/tb_interval_pulse_gen.sv
module tb_interval_pulse_gen;

  localparam int NG = 2;
  localparam int CW = 32;
  localparam int TN = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tickAdv = 1'b0;
  logic          outClkEn = 1'b0;
  logic [NG-1:0] intervalWr = '0;
  logic [CW-1:0] intervalData = '0;
  logic [NG-1:0] genEnable = '0;
  logic [NG-1:0] evtClr = '0;
  logic [NG-1:0] ovrClr = '0;
  logic [NG-1:0] pulseOut;
  logic [NG-1:0] evtFlag;
  logic [NG-1:0] ovrFlag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wdog = 0;
  bit done = 0;

  // reference model state
  longint mInt [NG];
  longint mCnt [NG];
  bit     mPulse [NG];
  int     expQ0 [$];
  int     expQ1 [$];
  logic [NG-1:0] prevP = '0;

  interval_pulse_gen #(.NUM_GEN(NG), .CNT_W(CW), .TICK_NS(TN)) dut (
    .clk(clk), .rstN(rstN), .tickAdv(tickAdv), .outClkEn(outClkEn),
    .intervalWr(intervalWr), .intervalData(intervalData), .genEnable(genEnable),
    .evtClr(evtClr), .ovrClr(ovrClr), .pulseOut(pulseOut), .evtFlag(evtFlag),
    .ovrFlag(ovrFlag)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Driver: predict from current inputs, push expected rise cycles, then clock
  task automatic runCycle();
    for (int g = 0; g < NG; g++) begin
      bit fire;
      fire = genEnable[g] && !intervalWr[g] && tickAdv && (mCnt[g] < TN);
      if (intervalWr[g]) begin
        mInt[g] = intervalData;
        mCnt[g] = intervalData;
      end else if (!genEnable[g]) begin
        mCnt[g] = mInt[g];
      end else if (tickAdv) begin
        mCnt[g] = fire ? mInt[g] : mCnt[g] - TN;
      end
      if (fire) begin
        if (!mPulse[g]) begin
          if (g == 0) expQ0.push_back(cyc + 1);
          else        expQ1.push_back(cyc + 1);
        end
        mPulse[g] = 1;
      end else if (mPulse[g] && outClkEn) begin
        mPulse[g] = 0;
      end
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    intervalWr = '0;
    evtClr = '0;
    ovrClr = '0;
  endtask

  task automatic idle(input int n);
    tickAdv = 1'b0;
    for (int i = 0; i < n; i++) runCycle();
  endtask

  task automatic advance(input int n);
    for (int i = 0; i < n; i++) begin
      tickAdv = 1'b1;
      runCycle();
    end
    tickAdv = 1'b0;
  endtask

  task automatic writeIv(input int g, input longint v);
    intervalData = CW'(v);
    intervalWr = NG'(1) << g;
    tickAdv = 1'b0;
    runCycle();
  endtask

  task automatic clearAll();
    tickAdv = 1'b0;
    evtClr = '1;
    ovrClr = '1;
    runCycle();
  endtask

  // Monitor: pop expected rise cycle on each observed rising pulse
  always @(negedge clk) begin
    if (rstN) begin
      for (int g = 0; g < NG; g++) begin
        if (pulseOut[g] && !prevP[g]) begin
          int e;
          e = -1;
          if (g == 0 && expQ0.size() > 0) e = expQ0.pop_front();
          if (g == 1 && expQ1.size() > 0) e = expQ1.pop_front();
          chk(e == cyc, (g == 0) ? "R3 gen0 pulse timing" : "R3 gen1 pulse timing", cyc, e);
        end
      end
      prevP = pulseOut;
    end
  end

  always @(posedge clk) begin
    wdog++;
    if (wdog > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", wdog, 100000);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < NG; g++) begin
      mInt[g] = 0; mCnt[g] = 0; mPulse[g] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(pulseOut == 0, "R1 pulseOut", pulseOut, 0);
    chk(evtFlag == 0, "R1 evtFlag", evtFlag, 0);
    chk(ovrFlag == 0, "R1 ovrFlag", ovrFlag, 0);

    // R2 R3 R10: two generators with different intervals, dense advances
    outClkEn = 1'b1;
    writeIv(0, 15);        // fires every 4 advances
    writeIv(1, 5);         // fires every 2 advances
    genEnable = 2'b11;
    advance(3);
    chk(evtFlag[0] == 0, "R2 gen0 no fire before 4th advance", evtFlag[0], 0);
    chk(evtFlag[1] == 1, "R10 gen1 fired on its own schedule", evtFlag[1], 1);
    advance(1);
    chk(evtFlag[0] == 1, "R2 gen0 fires on 4th advance", evtFlag[0], 1);
    advance(16);

    // R4: sparse advances, counting ignores idle cycles
    clearAll();
    writeIv(0, 12);        // 12,7,2 -> fires on 3rd advance
    for (int i = 0; i < 2; i++) begin
      advance(1);
      idle(4);
    end
    chk(evtFlag[0] == 0, "R4 idle cycles do not count", evtFlag[0], 0);
    advance(1);
    chk(evtFlag[0] == 1, "R4 fire on 3rd sparse advance", evtFlag[0], 1);
    for (int i = 0; i < 12; i++) begin
      tickAdv = (i % 3 == 0);
      runCycle();
    end
    tickAdv = 1'b0;

    // R7: pulse held until output-clock strobe
    genEnable = 2'b01;
    outClkEn = 1'b0;
    writeIv(0, 0);
    clearAll();
    idle(1);
    advance(1);
    chk(pulseOut[0] == 1, "R7 pulse rises after fire", pulseOut[0], 1);
    idle(3);
    chk(pulseOut[0] == 1, "R7 pulse held without strobe", pulseOut[0], 1);
    outClkEn = 1'b1;
    idle(1);
    chk(pulseOut[0] == 0, "R7 pulse drops after strobe", pulseOut[0], 0);

    // R11 R8 R9: zero interval fires every advance; flag collisions
    clearAll();
    chk(evtFlag[0] == 0 && ovrFlag[0] == 0, "R8 flags cleared", {evtFlag[0], ovrFlag[0]}, 0);
    tickAdv = 1'b1;
    evtClr = 2'b01;
    runCycle();
    tickAdv = 1'b0;
    chk(evtFlag[0] == 1, "R8 set wins over clear", evtFlag[0], 1);
    chk(ovrFlag[0] == 0, "R9 no overrun when flag cleared", ovrFlag[0], 0);
    advance(1);
    chk(ovrFlag[0] == 1, "R11 R9 overrun on next advance", ovrFlag[0], 1);
    ovrClr = 2'b01;
    idle(1);
    chk(ovrFlag[0] == 0 && evtFlag[0] == 1, "R9 ovr cleared, evt kept", {evtFlag[0], ovrFlag[0]}, 1);
    tickAdv = 1'b1;
    ovrClr = 2'b01;
    runCycle();
    tickAdv = 1'b0;
    chk(ovrFlag[0] == 1, "R9 new overrun wins over clear", ovrFlag[0], 1);

    // R6: write on the firing advance suppresses it
    clearAll();
    writeIv(0, 10);        // 10,5,0 -> fires on 3rd advance
    advance(2);
    intervalData = 10;
    intervalWr = 2'b01;
    tickAdv = 1'b1;
    runCycle();
    tickAdv = 1'b0;
    chk(evtFlag[0] == 0, "R6 write suppresses fire", evtFlag[0], 0);
    advance(2);
    chk(evtFlag[0] == 0, "R6 count restarted after write", evtFlag[0], 0);
    advance(1);
    chk(evtFlag[0] == 1, "R6 fire after full count", evtFlag[0], 1);

    // R5: disable mid-count, restart from interval; R10 gen0 untouched
    clearAll();
    genEnable = 2'b00;
    writeIv(1, 10);
    genEnable = 2'b10;
    advance(2);
    genEnable = 2'b00;
    advance(6);
    chk(evtFlag[1] == 0, "R5 no fire while disabled", evtFlag[1], 0);
    genEnable = 2'b10;
    advance(2);
    chk(evtFlag[1] == 0, "R5 count restarts on enable", evtFlag[1], 0);
    advance(1);
    chk(evtFlag[1] == 1, "R5 fire on 3rd advance after enable", evtFlag[1], 1);
    chk(evtFlag[0] == 0, "R10 gen0 unaffected", evtFlag[0], 0);

    // one-second setting with a 5 ns tick stores cleanly
    writeIv(0, 64'd999999995);
    genEnable = 2'b11;
    advance(4);
    chk(evtFlag[0] == 0, "R2 long interval no early fire", evtFlag[0], 0);

    idle(3);
    chk(expQ0.size() == 0 && expQ1.size() == 0, "R3 all expected pulses seen",
        expQ0.size() + expQ1.size(), 0);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule